// File: doc/BRIEF.md
# Binary Frame-Difference Event Readout

This block takes one binary contrast image per frame, 128 columns by 64 rows at one bit per pixel, delivered as a raster stream that starts after a frame-start strobe. It holds a one-bit-per-pixel reference frame. Once the last pixel of a frame has arrived, it scans the frame row by row. Each pixel gets a processed value, which is either the plain contrast bit or the difference between the contrast bit and the reference bit. The block reports the pixels whose processed value is nonzero.

In the full readout setting, every asserted pixel leaves as one address event on a valid/ready stream. An event carries the column, the row, and a sign bit that tells a rising change from a falling one. In the count-only setting no events leave the block. Both settings finish each frame with a one-cycle done pulse that presents the number of asserted pixels. The block supports three processing modes: plain contrast, difference against a stored background, and difference against the previous frame.

Top module: `evr_event_readout`

## Requirements
- R1: After reset, `ev_valid` and `cnt_done` are low, `cnt_value` is zero, and the reference frame holds all zeros.
- R2: After a `frame_start` seen while idle, the block accepts exactly 8192 pixels on cycles with `pix_valid` high, in raster order with x fastest. It ignores `pix_valid` outside a capture and ignores `frame_start` until the frame's done pulse.
- R3: `proc_mode`, `count_only` and `store_bg` are sampled with `frame_start`. Codes 2'b00 and 2'b11 select contrast mode, where the processed value is the current bit and the sign is always 1.
- R4: Code 2'b01 selects background mode, where the processed value is the current bit XOR the reference bit. In this mode the reference frame changes only when `store_bg` was sampled high, and then it takes that frame's image.
- R5: Code 2'b10 selects motion mode, where the processed value is the current bit XOR the previous reference. After readout the reference frame holds the current image.
- R6: `ev_sign` is 1 for a 0-to-1 change (current bit 1) and 0 for a 1-to-0 change (current bit 0).
- R7: Events are emitted only for nonzero processed pixels, and only after the last pixel of the frame has been accepted. They come in raster order: `ev_y` ascending, and within a row `ev_x` ascending. `ev_x` is 7 bits and `ev_y` is 6 bits.
- R8: While `ev_valid` is high and `ev_ready` is low, the event fields and `ev_valid` hold. Each accepted handshake consumes exactly one event.
- R9: With `count_only` sampled high, `ev_valid` stays low for the whole frame.
- R10: At the end of each frame, `cnt_done` pulses for exactly one cycle after the last event has been accepted. `cnt_value` (14 bits, range 0 to 8192) then equals the number of nonzero processed pixels and holds until the next `frame_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Starts capture of a frame |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | 1 | Binary contrast pixel |
| proc_mode | input | 2 | Processing mode code |
| count_only | input | 1 | 1: count only, no events |
| store_bg | input | 1 | Load this frame into the reference |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Event accepted by sink |
| ev_x | output | 7 | Event column |
| ev_y | output | 6 | Event row |
| ev_sign | output | 1 | Change direction |
| cnt_value | output | 14 | Asserted pixel count |
| cnt_done | output | 1 | One-cycle frame end pulse |

## Verification
The assertions assume that the sink eventually raises `ev_ready`. They also assume that `frame_start` may arrive at any time but has an effect only while the block is idle. The stimulus drives `ev_ready` from a random draw each cycle and inserts random gaps into the pixel stream. It issues junk pixels before a frame and a stray `frame_start` in mid-capture, and it changes the mode inputs after sampling. These cover the cases the block must ignore without breaking the stream rules. Dense, empty and corner-only frames push the scanner to both row ends and to a full-frame count.

// File: rtl/evr_pkg.sv
package evr_pkg;

  typedef enum logic [1:0] {
    MODE_CONTRAST = 2'b00,
    MODE_BACKGND  = 2'b01,
    MODE_MOTION   = 2'b10,
    MODE_RSVD     = 2'b11
  } proc_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_LOAD,
    ST_SCAN,
    ST_DONE
  } rd_state_e;

endpackage

// File: rtl/evr_frame_capture.sv
module evr_frame_capture #(
  parameter int COLS = 128,
  parameter int ROWS = 64,
  parameter int XW   = $clog2(COLS),
  parameter int YW   = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            pix_valid_i,
  input  logic            pix_data_i,
  output logic            row_we_o,
  output logic [YW-1:0]   row_idx_o,
  output logic [COLS-1:0] row_data_o,
  output logic            done_o
);

  localparam logic [XW-1:0] LAST_COL = XW'(COLS - 1);
  localparam logic [YW-1:0] LAST_ROW = YW'(ROWS - 1);

  logic            active_q, active_d;
  logic [XW-1:0]   col_q, col_d;
  logic [YW-1:0]   row_q, row_d;
  logic [COLS-1:0] sh_q, sh_d;
  logic            take, row_end, frame_end;

  assign take      = active_q & pix_valid_i;
  assign row_end   = take && (col_q == LAST_COL);
  assign frame_end = row_end && (row_q == LAST_ROW);

  always_comb begin
    active_d = active_q;
    col_d    = col_q;
    row_d    = row_q;
    sh_d     = sh_q;
    if (start_i) begin
      active_d = 1'b1;
      col_d    = '0;
      row_d    = '0;
    end else if (take) begin
      sh_d[col_q] = pix_data_i;
      if (row_end) begin
        col_d = '0;
        if (frame_end) begin
          row_d    = '0;
          active_d = 1'b0;
        end else begin
          row_d = row_q + 1'b1;
        end
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      col_q    <= '0;
      row_q    <= '0;
    end else begin
      active_q <= active_d;
      col_q    <= col_d;
      row_q    <= row_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) sh_q <= sh_d;
  end

  assign row_we_o   = row_end;
  assign row_idx_o  = row_q;
  assign row_data_o = sh_d;
  assign done_o     = frame_end;

  // R2: the controller may only restart capture when none is running
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |-> !active_q);

  // R2: a frame end closes the capture window
  a_r2_end_closes: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !active_q);

endmodule

// File: rtl/evr_row_store.sv
module evr_row_store #(
  parameter int W     = 128,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter bit CLEAR = 1'b0
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [DEPTH];

  generate
    if (CLEAR) begin : g_clear
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
          mem_q[waddr_i] <= wdata_i;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/evr_event_scan.sv
module evr_event_scan #(
  parameter int COLS = 128,
  parameter int XW   = $clog2(COLS),
  parameter int YW   = 6
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [COLS-1:0] mask_i,
  input  logic [COLS-1:0] sign_i,
  input  logic [YW-1:0]   row_i,
  output logic            ev_valid_o,
  input  logic            ev_ready_i,
  output logic [XW-1:0]   ev_x_o,
  output logic [YW-1:0]   ev_y_o,
  output logic            ev_sign_o,
  output logic            empty_o
);

  logic [COLS-1:0] mask_q, mask_d;
  logic [COLS-1:0] sign_q;
  logic [YW-1:0]   row_q;
  logic [XW-1:0]   pick;

  always_comb begin
    pick = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (mask_q[i]) pick = XW'(i);
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (load_i) begin
      mask_d = mask_i;
    end else if (ev_valid_o && ev_ready_i) begin
      mask_d[pick] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      sign_q <= sign_i;
      row_q  <= row_i;
    end
  end

  assign ev_valid_o = |mask_q;
  assign empty_o    = ~|mask_q;
  assign ev_x_o     = pick;
  assign ev_y_o     = row_q;
  assign ev_sign_o  = sign_q[pick];

  // R8: a stalled event stays put
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_valid_o && !ev_ready_i |=> ev_valid_o && $stable(ev_x_o)
                                  && $stable(ev_y_o) && $stable(ev_sign_o));

  // R7: within a row, consecutive events move to the right
  a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_valid_o && ev_ready_i |=> !ev_valid_o || (ev_x_o > $past(ev_x_o)));

  // R8: a new row is never loaded over pending events
  a_r8_no_clobber: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |-> empty_o);

endmodule

// File: rtl/evr_event_readout.sv
module evr_event_readout
  import evr_pkg::*;
#(
  parameter int COLS = 128,
  parameter int ROWS = 64,
  localparam int XW  = $clog2(COLS),
  localparam int YW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS * ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          pix_valid,
  input  logic          pix_data,
  input  logic [1:0]    proc_mode,
  input  logic          count_only,
  input  logic          store_bg,
  output logic          ev_valid,
  input  logic          ev_ready,
  output logic [XW-1:0] ev_x,
  output logic [YW-1:0] ev_y,
  output logic          ev_sign,
  output logic [CW-1:0] cnt_value,
  output logic          cnt_done
);

  localparam logic [YW-1:0] LAST_ROW = YW'(ROWS - 1);
  localparam logic [CW-1:0] MAX_CNT  = CW'(COLS * ROWS);

  // reset: asserted at once, released on the clock
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  rd_state_e  state_q, state_d;
  proc_mode_e cfg_mode_q, cfg_mode_d;
  logic       cfg_idle_q, cfg_idle_d;
  logic       cfg_store_q, cfg_store_d;
  logic [YW-1:0] rd_row_q, rd_row_d;
  logic [CW-1:0] cnt_q, cnt_d;

  logic            start_ok;
  logic            cap_we, cap_done;
  logic [YW-1:0]   cap_row;
  logic [COLS-1:0] cap_data;
  logic [COLS-1:0] cur_row, ref_row, row_mask;
  logic            ref_we, update_ref, scan_load, scan_empty;

  assign start_ok = frame_start && (state_q == ST_IDLE);

  evr_frame_capture #(.COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW)) i_capture (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_ok),
    .pix_valid_i(pix_valid),
    .pix_data_i (pix_data),
    .row_we_o   (cap_we),
    .row_idx_o  (cap_row),
    .row_data_o (cap_data),
    .done_o     (cap_done)
  );

  evr_row_store #(.W(COLS), .DEPTH(ROWS), .AW(YW), .CLEAR(1'b0)) i_cur_store (
    .clk    (clk),
    .rst_ni (rst_ni),
    .we_i   (cap_we),
    .waddr_i(cap_row),
    .wdata_i(cap_data),
    .raddr_i(rd_row_q),
    .rdata_o(cur_row)
  );

  evr_row_store #(.W(COLS), .DEPTH(ROWS), .AW(YW), .CLEAR(1'b1)) i_ref_store (
    .clk    (clk),
    .rst_ni (rst_ni),
    .we_i   (ref_we),
    .waddr_i(rd_row_q),
    .wdata_i(cur_row),
    .raddr_i(rd_row_q),
    .rdata_o(ref_row)
  );

  always_comb begin
    unique case (cfg_mode_q)
      MODE_BACKGND, MODE_MOTION: row_mask = cur_row ^ ref_row;
      default:                   row_mask = cur_row;
    endcase
  end

  assign update_ref = cfg_store_q || (cfg_mode_q == MODE_MOTION);
  assign ref_we     = (state_q == ST_LOAD) && update_ref;
  assign scan_load  = (state_q == ST_LOAD) && !cfg_idle_q && (|row_mask);

  evr_event_scan #(.COLS(COLS), .XW(XW), .YW(YW)) i_scan (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .load_i    (scan_load),
    .mask_i    (row_mask),
    .sign_i    (cur_row),
    .row_i     (rd_row_q),
    .ev_valid_o(ev_valid),
    .ev_ready_i(ev_ready),
    .ev_x_o    (ev_x),
    .ev_y_o    (ev_y),
    .ev_sign_o (ev_sign),
    .empty_o   (scan_empty)
  );

  always_comb begin
    state_d     = state_q;
    cfg_mode_d  = cfg_mode_q;
    cfg_idle_d  = cfg_idle_q;
    cfg_store_d = cfg_store_q;
    rd_row_d    = rd_row_q;
    cnt_d       = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d     = ST_CAPT;
          cfg_mode_d  = proc_mode_e'(proc_mode);
          cfg_idle_d  = count_only;
          cfg_store_d = store_bg;
          cnt_d       = '0;
        end
      end
      ST_CAPT: begin
        if (cap_done) begin
          state_d  = ST_LOAD;
          rd_row_d = '0;
        end
      end
      ST_LOAD: begin
        cnt_d = cnt_q + CW'($countones(row_mask));
        if (scan_load)                 state_d = ST_SCAN;
        else if (rd_row_q == LAST_ROW) state_d = ST_DONE;
        else                           rd_row_d = rd_row_q + 1'b1;
      end
      ST_SCAN: begin
        if (scan_empty) begin
          if (rd_row_q == LAST_ROW) begin
            state_d = ST_DONE;
          end else begin
            state_d  = ST_LOAD;
            rd_row_d = rd_row_q + 1'b1;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cfg_mode_q  <= MODE_CONTRAST;
      cfg_idle_q  <= 1'b0;
      cfg_store_q <= 1'b0;
      rd_row_q    <= '0;
      cnt_q       <= '0;
    end else begin
      state_q     <= state_d;
      cfg_mode_q  <= cfg_mode_d;
      cfg_idle_q  <= cfg_idle_d;
      cfg_store_q <= cfg_store_d;
      rd_row_q    <= rd_row_d;
      cnt_q       <= cnt_d;
    end
  end

  assign cnt_value = cnt_q;
  assign cnt_done  = (state_q == ST_DONE);

  // R9: count-only frames never raise the event stream
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_idle_q |-> !ev_valid);

  // R3: contrast-mode events always carry a positive sign
  a_r3_sign_one: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_valid && (cfg_mode_q == MODE_CONTRAST || cfg_mode_q == MODE_RSVD) |-> ev_sign);

  // R7: events appear only during readout, never during capture
  a_r7_after_capture: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_valid |-> state_q == ST_SCAN);

  // R10: the done strobe lasts one cycle
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_done |=> !cnt_done);

  // R10: the count never exceeds the pixel total
  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_value <= MAX_CNT);

  // R10: the count is frozen while no frame is in progress
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    state_q == ST_IDLE && !start_ok |=> $stable(cnt_value));

endmodule

// File: tb/test_evr_event_readout.sv
module test_evr_event_readout;

  localparam int CLK_PERIOD = 10;
  localparam int COLS = 128;
  localparam int ROWS = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start, pix_valid, pix_data, count_only, store_bg, ev_ready;
  logic [1:0]  proc_mode;
  logic        ev_valid, ev_sign, cnt_done;
  logic [6:0]  ev_x;
  logic [5:0]  ev_y;
  logic [13:0] cnt_value;

  evr_event_readout i_evr_event_readout (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_data(pix_data), .proc_mode(proc_mode), .count_only(count_only),
    .store_bg(store_bg), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_x(ev_x),
    .ev_y(ev_y), .ev_sign(ev_sign), .cnt_value(cnt_value), .cnt_done(cnt_done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [COLS-1:0] img  [ROWS];
  logic [COLS-1:0] refm [ROWS];
  logic [13:0] expq [$];
  bit   rand_ready = 1'b0;
  bit   in_idle_frame = 1'b0;
  int   idle_valid_seen = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sink side: random ready, record events that will handshake at next edge
  always @(negedge clk) begin
    if (rst_n !== 1'b1) ev_ready = 1'b0;
    else ev_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
    if (in_idle_frame && ev_valid === 1'b1) idle_valid_seen++;
    if (ev_valid === 1'b1 && ev_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R7 unexpected event", {ev_sign, ev_y, ev_x}, 0);
      end else begin
        logic [13:0] e;
        e = expq.pop_front();
        // R3 R6 R7: sign, row, column and order match the model
        check({ev_sign, ev_y, ev_x} == e, "R7 R6 R3 event {sign,y,x}",
              {ev_sign, ev_y, ev_x}, e);
      end
    end
  end

  task automatic fill_random(input int pct);
    for (int y = 0; y < ROWS; y++)
      for (int x = 0; x < COLS; x++)
        img[y][x] = (($urandom % 100) < pct);
  endtask

  task automatic fill_const(input logic v);
    for (int y = 0; y < ROWS; y++) img[y] = {COLS{v}};
  endtask

  task automatic run_frame(input logic [1:0] mode, input bit idle, input bit store,
                           input bit junk, input string tag);
    int cnt;
    bit diff;
    cnt = 0;
    diff = (mode == 2'b01) || (mode == 2'b10);
    for (int y = 0; y < ROWS; y++)
      for (int x = 0; x < COLS; x++) begin
        logic c, m;
        c = img[y][x];
        m = diff ? (c ^ refm[y][x]) : c;
        if (m) begin
          cnt++;
          if (!idle) expq.push_back({c, 6'(y), 7'(x)});
        end
      end
    if (store || mode == 2'b10)
      for (int y = 0; y < ROWS; y++) refm[y] = img[y];

    in_idle_frame   = idle;
    idle_valid_seen = 0;
    @(negedge clk);
    if (junk) begin
      // R2: pixels outside a capture are dropped
      pix_valid = 1'b1; pix_data = 1'b1;
      repeat (3) @(negedge clk);
      pix_valid = 1'b0;
    end
    proc_mode = mode; count_only = idle; store_bg = store; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    // R3: inputs changed after sampling have no effect on this frame
    proc_mode = ~mode; count_only = ~idle; store_bg = ~store;
    for (int y = 0; y < ROWS; y++)
      for (int x = 0; x < COLS; x++) begin
        while (($urandom % 10) == 0) begin
          pix_valid = 1'b0;
          @(negedge clk);
        end
        pix_valid = 1'b1;
        pix_data  = img[y][x];
        frame_start = (junk && y == 20 && x == 5); // R2: stray restart ignored
        @(negedge clk);
        frame_start = 1'b0;
      end
    pix_valid = 1'b0;
    while (cnt_done !== 1'b1) @(negedge clk);
    check(cnt_value == 14'(cnt), {"R10 count ", tag}, cnt_value, cnt);
    check(expq.size() == 0, {"R7 events left ", tag}, expq.size(), 0);
    if (idle) check(idle_valid_seen == 0, {"R9 events in count-only ", tag}, idle_valid_seen, 0);
    @(negedge clk);
    check(cnt_done == 1'b0, {"R10 done width ", tag}, cnt_done, 0);
    check(cnt_value == 14'(cnt), {"R10 count held ", tag}, cnt_value, cnt);
    expq.delete();
    in_idle_frame = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; frame_start = 1'b0; pix_valid = 1'b0; pix_data = 1'b0;
    proc_mode = 2'b00; count_only = 1'b0; store_bg = 1'b0;
    for (int y = 0; y < ROWS; y++) refm[y] = '0;
    repeat (3) @(negedge clk);
    check(ev_valid == 1'b0, "R1 ev_valid at reset", ev_valid, 0);
    check(cnt_done == 1'b0, "R1 cnt_done at reset", cnt_done, 0);
    check(cnt_value == 14'd0, "R1 cnt_value at reset", cnt_value, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R4: background against the cleared reference
    fill_random(5);  run_frame(2'b01, 1'b0, 1'b0, 1'b1, "bg-reset");
    // R3 R4: contrast frame that also stores the background
    fill_random(5);  run_frame(2'b00, 1'b0, 1'b1, 1'b0, "contrast-store");
    fill_random(5);  run_frame(2'b01, 1'b0, 1'b0, 1'b0, "bg");
    rand_ready = 1'b1;
    // R5: motion against the stored frame
    fill_random(6);  run_frame(2'b10, 1'b0, 1'b0, 1'b1, "motion");
    // R9: count only
    fill_random(6);  run_frame(2'b10, 1'b1, 1'b0, 1'b0, "motion-idle");
    // R5: unchanged scene gives nothing
    run_frame(2'b10, 1'b0, 1'b0, 1'b0, "motion-static");
    // R10: full frame count
    fill_const(1'b1); run_frame(2'b00, 1'b0, 1'b0, 1'b0, "all-ones");
    // R3 R7: reserved code acts as contrast, row ends
    fill_const(1'b0); img[0][0] = 1'b1; img[ROWS-1][COLS-1] = 1'b1;
    run_frame(2'b11, 1'b0, 1'b0, 1'b0, "corners");
    // R6: vanished pixels carry sign 0
    fill_const(1'b0); run_frame(2'b10, 1'b0, 1'b0, 1'b0, "motion-clear");
    // R4 R9: background count with no events
    fill_random(10); run_frame(2'b01, 1'b1, 1'b0, 1'b0, "bg-idle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule